// File: doc/BRIEF.md
# Status-Gated External Register Router

This block sits between a DSP core and its small bank of external registers. Each access to one of three registers names a register select and a read or write strobe. The block decides whether the access goes out to external memory as a request, or stays inside the block. A single routing flag in the DSP status word makes that decision. A second status flag is stored and can be read back, but it has no effect on routing.

When routing is off, each register falls back to its own local behaviour. The first pointer register acts as a plain storage word that software can program. The second pointer register returns a free-running pseudo-random word on reads and drops its writes. The write-only port drops its writes. The address generator that feeds memory is outside the block. It is modelled as an address input, and the block answers it with a one-cycle step pulse after every routed access.

Top module: `xreg_router`

## Requirements
- R1: On a clock edge where `status_we` is high, the block captures bit 5 of `status_wdata` into `route_en` and bit 6 into `aux_flag`, and both become visible from the next cycle. Both are 0 after reset, and they hold their values while `status_we` is low.
- R2: Routing follows only `route_en`. Status values 0x0020 and 0x0060 enable memory access, while 0x0040 (bit 6 alone) and 0x0000 leave every register local.
- R3: With routing on, a read of `reg_sel`=0 (first pointer) raises `mem_rd` in the same cycle, with `mem_addr` equal to `ext_addr`, and `rd_data` returns `mem_rdata`.
- R4: With routing on, a write to `reg_sel`=0 or `reg_sel`=1 raises `mem_wr` in the same cycle, with `mem_wdata` equal to `wr_data` and `mem_addr` equal to `ext_addr`.
- R5: With routing off, a write to `reg_sel`=0 produces no memory request and stores `wr_data` locally. A later read with routing off returns the last stored word and raises no `mem_rd`. The stored word is 0 after reset.
- R6: With routing on, a read of `reg_sel`=1 (second pointer) raises `mem_rd` and returns `mem_rdata`.
- R7: With routing off, a read of `reg_sel`=1 returns the current noise word and makes no memory request. The noise word is 0xACE1 at reset and advances on every clock edge by a right shift, and when the bit shifted out is 1 the result is XORed with 0xB400. A write to `reg_sel`=1 with routing off makes no memory request.
- R8: `reg_sel`=2 (write port) raises `mem_wr` on a write when routing is on and makes no request when routing is off. A read of it never raises `mem_rd` and returns 0.
- R9: `addr_step` is high in exactly the cycles in which `mem_rd` or `mem_wr` is high, so it lasts one cycle for each single-cycle access.
- R10: `reg_sel`=3 selects nothing. No memory request is made, and `rd_data` is 0 whenever no read is decoded.
- R11: When `rd_en` and `wr_en` are both high, the access is treated as a write and the read is ignored: no `mem_rd` is raised and `rd_data` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_we | input | 1 | Strobe that loads the status flags |
| status_wdata | input | 16 | Status word written by the DSP |
| route_en | output | 1 | Stored routing flag (status bit 5) |
| aux_flag | output | 1 | Stored auxiliary flag (status bit 6), read-back only |
| reg_sel | input | 2 | Register select: 0 first pointer, 1 second pointer, 2 write port, 3 none |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data from the DSP |
| rd_data | output | 16 | Read data returned to the DSP |
| ext_addr | input | 21 | Address from the external address generator |
| mem_rd | output | 1 | External memory read request |
| mem_wr | output | 1 | External memory write request |
| mem_addr | output | 21 | Memory request address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the request cycle |
| addr_step | output | 1 | One-cycle pulse that advances the address generator |

## Verification
The assertions check several properties on every cycle:
- No memory request is made while routing is off.
- The write port never issues a read.
- A read that coincides with a write is never sent out.
- The step pulse matches the memory requests exactly.
- The status flags reload from the status write.

Only the bench scenarios can show the data behaviour that depends on history. These cover the local word of the first pointer surviving across later accesses, the exact sequence of the noise word, and the status value 0x0040 leaving every register local.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
  localparam int XR_DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_PTR_A = 2'd0,
    SEL_PTR_B = 2'd1,
    SEL_WPORT = 2'd2,
    SEL_IDLE  = 2'd3
  } xsel_e;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_MEM   = 2'd1,
    SRC_LOCAL = 2'd2,
    SRC_NOISE = 2'd3
  } rsrc_e;

  // Galois step, right shifting; feedback applied when the dropped bit is 1
  function automatic logic [XR_DATA_W-1:0] noise_next(
    input logic [XR_DATA_W-1:0] cur,
    input logic [XR_DATA_W-1:0] mask
  );
    logic [XR_DATA_W-1:0] sh;
    sh = cur >> 1;
    return cur[0] ? (sh ^ mask) : sh;
  endfunction
endpackage

// File: rtl/xreg_flags.sv
module xreg_flags #(
  parameter int STAT_W    = 16,
  parameter int ROUTE_BIT = 5,
  parameter int AUX_BIT   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [STAT_W-1:0] word,
  output logic              route_q,
  output logic              aux_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route_q <= 1'b0;
      aux_q   <= 1'b0;
    end else if (load) begin
      route_q <= word[ROUTE_BIT];
      aux_q   <= word[AUX_BIT];
    end
  end
endmodule

// File: rtl/xreg_noise.sv
module xreg_noise
  import xreg_pkg::*;
#(
  parameter logic [XR_DATA_W-1:0] SEED = 16'hACE1,
  parameter logic [XR_DATA_W-1:0] MASK = 16'hB400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [XR_DATA_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n) value <= SEED;
    else        value <= noise_next(value, MASK);
  end
endmodule

// File: rtl/xreg_decode.sv
module xreg_decode
  import xreg_pkg::*;
(
  input  logic  route_en,
  input  xsel_e sel,
  input  logic  rd_en,
  input  logic  wr_en,
  output logic  mem_rd,
  output logic  mem_wr,
  output logic  local_wr,
  output rsrc_e rsrc
);
  logic eff_rd;
  assign eff_rd = rd_en & ~wr_en;

  always_comb begin
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    local_wr = 1'b0;
    rsrc     = SRC_ZERO;
    unique case (sel)
      SEL_PTR_A: begin
        if (route_en) begin
          mem_rd = eff_rd;
          mem_wr = wr_en;
          if (eff_rd) rsrc = SRC_MEM;
        end else begin
          local_wr = wr_en;
          if (eff_rd) rsrc = SRC_LOCAL;
        end
      end
      SEL_PTR_B: begin
        if (route_en) begin
          mem_rd = eff_rd;
          mem_wr = wr_en;
          if (eff_rd) rsrc = SRC_MEM;
        end else if (eff_rd) begin
          rsrc = SRC_NOISE;
        end
      end
      SEL_WPORT: mem_wr = route_en & wr_en;
      default: ;
    endcase
  end
endmodule

// File: rtl/xreg_router.sv
module xreg_router
  import xreg_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int STAT_W = 16,
  parameter int ROUTE_BIT = 5,
  parameter int AUX_BIT = 6,
  parameter logic [XR_DATA_W-1:0] NOISE_SEED = 16'hACE1,
  parameter logic [XR_DATA_W-1:0] NOISE_MASK = 16'hB400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 status_we,
  input  logic [STAT_W-1:0]    status_wdata,
  output logic                 route_en,
  output logic                 aux_flag,
  input  logic [1:0]           reg_sel,
  input  logic                 rd_en,
  input  logic                 wr_en,
  input  logic [XR_DATA_W-1:0] wr_data,
  output logic [XR_DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0]    ext_addr,
  output logic                 mem_rd,
  output logic                 mem_wr,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [XR_DATA_W-1:0] mem_wdata,
  input  logic [XR_DATA_W-1:0] mem_rdata,
  output logic                 addr_step
);
  logic                 local_wr;
  rsrc_e                rsrc;
  logic [XR_DATA_W-1:0] noise_w;
  logic [XR_DATA_W-1:0] ptr_local_q;

  xreg_flags #(
    .STAT_W(STAT_W), .ROUTE_BIT(ROUTE_BIT), .AUX_BIT(AUX_BIT)
  ) u_flags (
    .clk(clk), .rst_n(rst_n), .load(status_we), .word(status_wdata),
    .route_q(route_en), .aux_q(aux_flag)
  );

  xreg_noise #(.SEED(NOISE_SEED), .MASK(NOISE_MASK)) u_noise (
    .clk(clk), .rst_n(rst_n), .value(noise_w)
  );

  xreg_decode u_dec (
    .route_en(route_en), .sel(xsel_e'(reg_sel)), .rd_en(rd_en), .wr_en(wr_en),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .local_wr(local_wr), .rsrc(rsrc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ptr_local_q <= '0;
    else if (local_wr) ptr_local_q <= wr_data;
  end

  always_comb begin
    unique case (rsrc)
      SRC_MEM:   rd_data = mem_rdata;
      SRC_LOCAL: rd_data = ptr_local_q;
      SRC_NOISE: rd_data = noise_w;
      default:   rd_data = '0;
    endcase
  end

  assign mem_addr  = ext_addr;
  assign mem_wdata = wr_data;
  assign addr_step = mem_rd | mem_wr;
endmodule

// File: rtl/xreg_router_chk.sv
module xreg_router_chk #(
  parameter int STAT_W = 16,
  parameter int ROUTE_BIT = 5,
  parameter int AUX_BIT = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              status_we,
  input logic [STAT_W-1:0] status_wdata,
  input logic              route_en,
  input logic              aux_flag,
  input logic [1:0]        reg_sel,
  input logic              rd_en,
  input logic              wr_en,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              addr_step
);
  p_flag_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_we |=> (route_en == $past(status_wdata[ROUTE_BIT])) &&
                  (aux_flag == $past(status_wdata[AUX_BIT])));

  p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_we && $past(rst_n)) |=> $stable(route_en) && $stable(aux_flag));

  p_no_mem_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !route_en |-> !mem_rd && !mem_wr);

  p_wport_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd2) |-> !mem_rd);

  p_step_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> addr_step);

  p_step_only_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    addr_step |-> (mem_rd || mem_wr));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> !mem_rd && !mem_wr);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en) |-> !mem_rd);

  p_req_needs_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr}) <= 1);
endmodule

bind xreg_router xreg_router_chk #(
  .STAT_W(STAT_W), .ROUTE_BIT(ROUTE_BIT), .AUX_BIT(AUX_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .status_we(status_we), .status_wdata(status_wdata),
  .route_en(route_en), .aux_flag(aux_flag), .reg_sel(reg_sel), .rd_en(rd_en),
  .wr_en(wr_en), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_step(addr_step)
);

// File: tb/xreg_router_tb.sv
`timescale 1ns/1ps
module xreg_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        status_we = 1'b0;
  logic [15:0] status_wdata = '0;
  logic        route_en, aux_flag;
  logic [1:0]  reg_sel = 2'd3;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic [20:0] ext_addr = '0;
  logic        mem_rd, mem_wr, addr_step;
  logic [20:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;

  int n_checks = 0;
  int n_fail = 0;
  logic [15:0] ref_noise;

  always #4 clk = ~clk;

  xreg_router u_dut (
    .clk(clk), .rst_n(rst_n), .status_we(status_we), .status_wdata(status_wdata),
    .route_en(route_en), .aux_flag(aux_flag), .reg_sel(reg_sel), .rd_en(rd_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .ext_addr(ext_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .addr_step(addr_step)
  );

  // Reference noise word: the feedback written out bit by bit for taps 15,13,12,10
  always @(posedge clk) begin
    if (!rst_n) ref_noise <= 16'hACE1;
    else begin
      logic o;
      o = ref_noise[0];
      ref_noise <= {o, ref_noise[15], ref_noise[14] ^ o, ref_noise[13] ^ o,
                    ref_noise[12], ref_noise[11] ^ o, ref_noise[10:1]};
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] s, input logic r, input logic w,
                       input logic [15:0] d);
    @(negedge clk);
    reg_sel = s; rd_en = r; wr_en = w; wr_data = d;
    #1;
  endtask

  task automatic idle();
    drive(2'd3, 1'b0, 1'b0, 16'h0);
  endtask

  task automatic set_status(input logic [15:0] v);
    @(negedge clk);
    status_we = 1'b1; status_wdata = v;
    @(negedge clk);
    status_we = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check(route_en == 1'b0, "R1 reset route", route_en, 0);
    check(aux_flag == 1'b0, "R1 reset aux", aux_flag, 0);
    drive(2'd0, 1'b1, 1'b0, 16'h0);
    check(rd_data == 16'h0 && !mem_rd, "R5 reset local word", rd_data, 0);
    idle();
  endtask

  task automatic t_flags();
    set_status(16'h0040);
    check(route_en == 1'b0, "R2 0x0040 route", route_en, 0);
    check(aux_flag == 1'b1, "R1 aux readback", aux_flag, 1);
    drive(2'd0, 1'b0, 1'b1, 16'h1357);
    check(!mem_wr && !addr_step, "R2 0x0040 no memory write", mem_wr, 0);
    drive(2'd1, 1'b0, 1'b1, 16'h2468);
    check(!mem_wr, "R2 0x0040 second pointer stays local", mem_wr, 0);
    idle();
    set_status(16'h0020);
    check(route_en == 1'b1 && aux_flag == 1'b0, "R1 0x0020 flags",
          {route_en, aux_flag}, 2'b10);
    set_status(16'h0060);
    check(route_en == 1'b1 && aux_flag == 1'b1, "R2 0x0060 flags",
          {route_en, aux_flag}, 2'b11);
    drive(2'd0, 1'b0, 1'b1, 16'h0F0F);
    check(mem_wr, "R2 0x0060 routes", mem_wr, 1);
    idle();
  endtask

  task automatic t_ptr_a_routed();
    set_status(16'h0020);
    ext_addr = 21'h1ABCD; mem_rdata = 16'hBEEF;
    drive(2'd0, 1'b1, 1'b0, 16'h0);
    check(mem_rd && !mem_wr, "R3 read request", mem_rd, 1);
    check(mem_addr == 21'h1ABCD, "R3 address", mem_addr, 21'h1ABCD);
    check(rd_data == 16'hBEEF, "R3 read data", rd_data, 16'hBEEF);
    check(addr_step, "R9 step on read", addr_step, 1);
    idle();
    check(!addr_step, "R9 step is one cycle", addr_step, 0);
    ext_addr = 21'h00042;
    drive(2'd0, 1'b0, 1'b1, 16'hC0DE);
    check(mem_wr && mem_wdata == 16'hC0DE && mem_addr == 21'h00042,
          "R4 first pointer write", mem_wdata, 16'hC0DE);
    idle();
  endtask

  task automatic t_ptr_a_local();
    set_status(16'h0000);
    drive(2'd0, 1'b0, 1'b1, 16'h5A5A);
    check(!mem_wr && !addr_step, "R5 local write no request", mem_wr, 0);
    idle();
    drive(2'd1, 1'b1, 1'b0, 16'h0);
    idle();
    mem_rdata = 16'h7777;
    drive(2'd0, 1'b1, 1'b0, 16'h0);
    check(rd_data == 16'h5A5A && !mem_rd, "R5 local readback", rd_data, 16'h5A5A);
    idle();
  endtask

  task automatic t_ptr_b();
    logic [15:0] first;
    set_status(16'h0020);
    mem_rdata = 16'h4321;
    drive(2'd1, 1'b1, 1'b0, 16'h0);
    check(mem_rd && rd_data == 16'h4321, "R6 routed read", rd_data, 16'h4321);
    drive(2'd1, 1'b0, 1'b1, 16'h9999);
    check(mem_wr && mem_wdata == 16'h9999, "R4 second pointer write", mem_wdata, 16'h9999);
    idle();
    set_status(16'h0000);
    drive(2'd1, 1'b1, 1'b0, 16'h0);
    check(!mem_rd && rd_data == ref_noise, "R7 noise read", rd_data, ref_noise);
    first = rd_data;
    drive(2'd1, 1'b1, 1'b0, 16'h0);
    check(rd_data == ref_noise && rd_data != first, "R7 noise advances", rd_data, ref_noise);
    drive(2'd1, 1'b0, 1'b1, 16'hAAAA);
    check(!mem_wr, "R7 local write dropped", mem_wr, 0);
    idle();
  endtask

  task automatic t_wport();
    set_status(16'h0060);
    mem_rdata = 16'hFFFF;
    drive(2'd2, 1'b0, 1'b1, 16'h1111);
    check(mem_wr && mem_wdata == 16'h1111, "R8 routed write", mem_wr, 1);
    drive(2'd2, 1'b1, 1'b0, 16'h0);
    check(!mem_rd && rd_data == 16'h0, "R8 read never memory", rd_data, 0);
    idle();
    set_status(16'h0000);
    drive(2'd2, 1'b0, 1'b1, 16'h2222);
    check(!mem_wr, "R8 unrouted write dropped", mem_wr, 0);
    idle();
  endtask

  task automatic t_idle_and_both();
    set_status(16'h0020);
    drive(2'd3, 1'b1, 1'b1, 16'h3333);
    check(!mem_rd && !mem_wr && rd_data == 16'h0, "R10 no register", rd_data, 0);
    mem_rdata = 16'h5555;
    drive(2'd0, 1'b1, 1'b1, 16'h6666);
    check(mem_wr && !mem_rd && rd_data == 16'h0, "R11 write wins", {mem_rd, mem_wr}, 2'b01);
    idle();
    set_status(16'h0000);
    drive(2'd0, 1'b1, 1'b1, 16'h7E7E);
    check(rd_data == 16'h0 && !mem_wr, "R11 local write wins", rd_data, 0);
    drive(2'd0, 1'b1, 1'b0, 16'h0);
    check(rd_data == 16'h7E7E, "R11 local word stored", rd_data, 16'h7E7E);
    idle();
  endtask

  bit done = 1'b0;

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_flags();
    t_ptr_a_routed();
    t_ptr_a_local();
    t_ptr_b();
    t_wport();
    t_idle_and_both();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule